// File: doc/BRIEF.md
# Wide Fixed-Point Accumulator for Floating-Point Summands

This block sums a stream of floating-point numbers exactly. It does not use a floating-point adder in the loop. Each incoming summand is decoded and its significand is shifted to the bit position its exponent calls for. The shifted value is then added into a wide two's-complement fixed-point register. The register's least and most significant bits have weights fixed by parameters. When those weights enclose every summand and the largest possible sum, no rounding ever happens.

Only the input side depends on the exponent. The alignment shifter sits in its own register stage ahead of the loop. The loop itself is a single fixed-point add, split into two halves with carry-select.

The output is the raw fixed-point sum. Converting it back to floating point with a leading-zero count and a shift is left to a separate unit, which several such accumulators can share. Three sticky flags report events:
- the sum left its range;
- low-order bits were dropped;
- an infinity or NaN arrived.

Top module: `fp_wide_accum`

## Requirements
- R1: A summand is decoded as follows. The sign is bit EXP_W+FRAC_W. The exponent field is bits EXP_W+FRAC_W-1 down to FRAC_W. The fraction is the low FRAC_W bits. The exponent bias is 2^(EXP_W-1)-1. The output accSum is a two's-complement number whose bit i has weight 2^(LSB_WT+i). Its width is ACC_W = MSB_WT-LSB_WT+1, which is 63 with the default parameters.
- R2: A summand sampled with inValid high at clock edge k appears in accSum after edge k+1. Summands may arrive on every cycle, and each one is added exactly once.
- R3: A summand whose sign bit is 1 is subtracted from the sum.
- R4: An exponent field of 0 means the significand's hidden bit is 0 and the effective exponent is 1. This covers both zero and subnormal summands.
- R5: Significand bits whose weight is below 2^LSB_WT are dropped from the magnitude before the sign is applied. Whenever a dropped bit is nonzero, the sticky flag inexact is set.
- R6: The sticky flag overflow is set in either of two cases. The first case is a summand whose aligned magnitude is 2^(ACC_W-1) or more; such a summand is not added. The second case is an addition whose true signed result lies outside the ACC_W-bit range; the sum then keeps its low ACC_W bits.
- R7: A summand whose exponent field is all ones is not added, and it sets the sticky flag invalid.
- R8: A clear sampled at edge k makes accSum and all three flags zero after edge k. Summands sampled at edge k or at edge k-1 are discarded.
- R9: A carry out of the low half of the loop adder reaches the high half within the same cycle, so a carry that ripples through all ACC_W bits gives the correct sum.
- R10: In a cycle with no summand in flight and no clear, accSum and the flags keep their values.
- R11: After reset, accSum is zero and all three flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous clear of the sum, the flags and the in-flight summands |
| inValid | input | 1 | The summand on inData is valid |
| inData | input | EXP_W+FRAC_W+1 | Floating-point summand: sign, exponent field, fraction |
| accSum | output | ACC_W | Two's-complement fixed-point sum |
| overflow | output | 1 | Sticky: the sum or a summand left the range |
| inexact | output | 1 | Sticky: nonzero bits were dropped below the LSB weight |
| invalid | output | 1 | Sticky: an infinity or NaN summand arrived |

## Verification
The hardest condition to reach is a carry that runs the full width of the accumulator and crosses the split between the two adder halves. With the default LSB weight of 2^-38, ordinary operands never touch the low bits. The stimulus therefore uses summands of weight 1 and 2, whose exponents land exactly at the accumulator's bottom. It first drives the sum to minus one, so every bit is set, and then adds one back. Range overflow is reached in a similar way: 2^61 is added twice to pass the signed limit. A summand is also sent in the cycle just before a clear, to confirm that the in-flight value is discarded.

// File: rtl/fpacc_pkg.sv
package fpacc_pkg;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic loadStage;  // capture the aligned summand into the stage register
    logic accumEn;    // fold the staged summand into the sum
    logic flush;      // zero the sum and the sticky flags
  } ctrlStrobes_t;

endpackage

// File: rtl/fpacc_align.sv
// Decodes a floating-point summand and places its significand at the
// accumulator's bit weights. Purely combinational.
module fpacc_align #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int LSB_WT = -38,
  parameter int ACC_W  = 63
) (
  input  logic [EXP_W+FRAC_W:0] summand,
  output logic [ACC_W-1:0]      term,     // signed, aligned
  output logic                  dropped,  // nonzero bits fell below LSB
  output logic                  tooBig,   // magnitude does not fit
  output logic                  special   // exponent field all ones
);
  localparam int SIG_W = FRAC_W + 1;
  localparam int WW    = ACC_W + 2 * SIG_W;
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;

  logic              signBit;
  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] fracField;
  logic              hidden;
  logic [EXP_W-1:0]  effExp;
  logic [SIG_W-1:0]  sig;
  logic [WW-1:0]     base;
  logic [WW-1:0]     shifted;
  logic [ACC_W-2:0]  mag;
  int                sh;

  assign signBit   = summand[EXP_W+FRAC_W];
  assign expField  = summand[EXP_W+FRAC_W-1:FRAC_W];
  assign fracField = summand[FRAC_W-1:0];
  assign hidden    = |expField;
  assign effExp    = hidden ? expField : EXP_W'(1);
  assign sig       = {hidden, fracField};
  assign base      = {{(WW-SIG_W){1'b0}}, sig};

  always_comb begin
    sh      = int'(effExp) - BIAS - FRAC_W - LSB_WT;
    shifted = '0;
    mag     = '0;
    dropped = 1'b0;
    tooBig  = 1'b0;
    special = &expField;
    if (special) begin
      // not aligned at all
    end else if (sh >= ACC_W - 1) begin
      tooBig = |sig;
    end else if (sh <= -SIG_W) begin
      dropped = |sig;
    end else begin
      shifted = base << (sh + SIG_W);
      mag     = shifted[SIG_W+ACC_W-2:SIG_W];
      dropped = |shifted[SIG_W-1:0];
      tooBig  = |shifted[WW-1:SIG_W+ACC_W-1];
    end
    if (signBit) term = -{1'b0, mag};
    else         term = {1'b0, mag};
  end
endmodule

// File: rtl/fpacc_csadd.sv
// Loop adder; a one-level carry-select split or a plain add.
module fpacc_csadd #(
  parameter int WIDTH        = 63,
  parameter bit CARRY_SELECT = 1'b1
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] sum
);
  generate
    if (CARRY_SELECT && WIDTH >= 4) begin : g_csel
      localparam int LO_W = WIDTH / 2;
      localparam int HI_W = WIDTH - LO_W;
      logic [LO_W:0]     loSum;
      logic [HI_W-1:0]   hiNoCarry;
      logic [HI_W-1:0]   hiCarry;
      assign loSum     = {1'b0, a[LO_W-1:0]} + {1'b0, b[LO_W-1:0]};
      assign hiNoCarry = a[WIDTH-1:LO_W] + b[WIDTH-1:LO_W];
      assign hiCarry   = a[WIDTH-1:LO_W] + b[WIDTH-1:LO_W] + HI_W'(1);
      assign sum = {(loSum[LO_W] ? hiCarry : hiNoCarry), loSum[LO_W-1:0]};
    end else begin : g_plain
      assign sum = a + b;
    end
  endgenerate
endmodule

// File: rtl/fpacc_ctrl.sv
// Tracks the valid bit of the staged summand and issues strobes.
module fpacc_ctrl
  import fpacc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         clear,
  output ctrlStrobes_t strobes
);
  logic stageValidQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageValidQ <= 1'b0;
    else       stageValidQ <= inValid && !clear;
  end

  always_comb begin
    strobes.loadStage = inValid && !clear;
    strobes.accumEn   = stageValidQ && !clear;
    strobes.flush     = clear;
  end
endmodule

// File: rtl/fpacc_datapath.sv
// Alignment stage, loop adder and sticky flags.
module fpacc_datapath
  import fpacc_pkg::*;
#(
  parameter int EXP_W        = 8,
  parameter int FRAC_W       = 23,
  parameter int LSB_WT       = -38,
  parameter int ACC_W        = 63,
  parameter bit CARRY_SELECT = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          strobes,
  input  logic [EXP_W+FRAC_W:0] inData,
  output logic [ACC_W-1:0]      accSum,
  output logic                  overflow,
  output logic                  inexact,
  output logic                  invalid
);
  logic [ACC_W-1:0] alignTerm;
  logic             alignDrop, alignBig, alignSpecial;

  logic [ACC_W-1:0] stageTerm;
  logic             stageDrop, stageBig, stageSpecial;

  logic [ACC_W-1:0] accQ;
  logic [ACC_W-1:0] loopSum;
  logic             addOvf;
  logic             skipAdd;

  fpacc_align #(
    .EXP_W (EXP_W),
    .FRAC_W(FRAC_W),
    .LSB_WT(LSB_WT),
    .ACC_W (ACC_W)
  ) align_i (
    .summand(inData),
    .term   (alignTerm),
    .dropped(alignDrop),
    .tooBig (alignBig),
    .special(alignSpecial)
  );

  // Stage register: the only place the exponent-dependent shift lands.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageTerm    <= '0;
      stageDrop    <= 1'b0;
      stageBig     <= 1'b0;
      stageSpecial <= 1'b0;
    end else if (strobes.loadStage) begin
      stageTerm    <= alignTerm;
      stageDrop    <= alignDrop;
      stageBig     <= alignBig;
      stageSpecial <= alignSpecial;
    end
  end

  fpacc_csadd #(
    .WIDTH       (ACC_W),
    .CARRY_SELECT(CARRY_SELECT)
  ) add_i (
    .a  (accQ),
    .b  (stageTerm),
    .sum(loopSum)
  );

  assign skipAdd = stageBig || stageSpecial;
  assign addOvf  = (accQ[ACC_W-1] == stageTerm[ACC_W-1]) &&
                   (loopSum[ACC_W-1] != accQ[ACC_W-1]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ     <= '0;
      overflow <= 1'b0;
      inexact  <= 1'b0;
      invalid  <= 1'b0;
    end else if (strobes.flush) begin
      accQ     <= '0;
      overflow <= 1'b0;
      inexact  <= 1'b0;
      invalid  <= 1'b0;
    end else if (strobes.accumEn) begin
      if (!skipAdd) accQ <= loopSum;
      overflow <= overflow || stageBig || (!skipAdd && addOvf);
      inexact  <= inexact || (!stageSpecial && stageDrop);
      invalid  <= invalid || stageSpecial;
    end
  end

  assign accSum = accQ;
endmodule

// File: rtl/fp_wide_accum.sv
// Thin top: control plus datapath.
module fp_wide_accum
  import fpacc_pkg::*;
#(
  parameter int EXP_W        = 8,
  parameter int FRAC_W       = 23,
  parameter int MSB_WT       = 24,
  parameter int LSB_WT       = -38,
  parameter bit CARRY_SELECT = 1'b1,
  localparam int ACC_W       = MSB_WT - LSB_WT + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  clear,
  input  logic                  inValid,
  input  logic [EXP_W+FRAC_W:0] inData,
  output logic [ACC_W-1:0]      accSum,
  output logic                  overflow,
  output logic                  inexact,
  output logic                  invalid
);
  ctrlStrobes_t strobes;

  fpacc_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .clear  (clear),
    .strobes(strobes)
  );

  fpacc_datapath #(
    .EXP_W       (EXP_W),
    .FRAC_W      (FRAC_W),
    .LSB_WT      (LSB_WT),
    .ACC_W       (ACC_W),
    .CARRY_SELECT(CARRY_SELECT)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .inData  (inData),
    .accSum  (accSum),
    .overflow(overflow),
    .inexact (inexact),
    .invalid (invalid)
  );
endmodule

// File: rtl/fp_wide_accum_chk.sv
module fp_wide_accum_chk #(
  parameter int ACC_W = 63
) (
  input logic             clk,
  input logic             rstN,
  input logic             clear,
  input logic             inValid,
  input logic [ACC_W-1:0] accSum,
  input logic             overflow,
  input logic             inexact,
  input logic             invalid
);
  // A summand is in flight between its sampling edge and the next edge.
  logic pendQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= 1'b0;
    else       pendQ <= inValid && !clear;
  end

  a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (accSum == '0 && !overflow && !inexact && !invalid));

  a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !clear) |=> overflow);

  a_r5_inexact_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (inexact && !clear) |=> inexact);

  a_r7_invalid_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (invalid && !clear) |=> invalid);

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!pendQ && !clear) |=> $stable({accSum, overflow, inexact, invalid}));
endmodule

bind fp_wide_accum fp_wide_accum_chk #(.ACC_W(ACC_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .clear   (clear),
  .inValid (inValid),
  .accSum  (accSum),
  .overflow(overflow),
  .inexact (inexact),
  .invalid (invalid)
);

// File: tb/fp_wide_accum_tb_top.sv
module fp_wide_accum_tb_top;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int MSB_WT = 24;
  localparam int LSB_WT = -38;
  localparam int ACC_W  = MSB_WT - LSB_WT + 1;
  localparam int BIAS   = 127;
  localparam int BW     = 200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clear = 1'b0;
  logic inValid = 1'b0;
  logic [31:0] inData = '0;
  logic [ACC_W-1:0] accSum;
  logic overflow, inexact, invalid;

  int cyc = 0;
  int checkCnt = 0;
  int failCnt = 0;

  typedef struct {
    int               due;
    logic [ACC_W-1:0] sum;
    logic             ovf;
    logic             inx;
    logic             inv;
    string            req;
  } item_t;
  item_t sb[$];

  // Bench-side expected state.
  logic [ACC_W-1:0] mSum = '0;
  logic mOvf = 1'b0, mInx = 1'b0, mInv = 1'b0;

  fp_wide_accum dut_i (
    .clk(clk), .rstN(rstN), .clear(clear), .inValid(inValid), .inData(inData),
    .accSum(accSum), .overflow(overflow), .inexact(inexact), .invalid(invalid)
  );

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] fp(input logic s, input int e, input int f);
    return {s, 8'(e), 23'(f)};
  endfunction

  // Expected effect of one summand, from R1, R3..R7.
  function automatic void modelAdd(input logic [31:0] f);
    logic [BW-1:0] mag, sigW, lim;
    logic signed [BW-1:0] w, slim;
    int e, pos;
    logic hid;
    e = int'(f[30:23]);
    if (e == 255) begin mInv = 1'b1; return; end
    hid  = (e != 0);
    sigW = BW'({hid, f[22:0]});
    pos  = (hid ? e : 1) - BIAS - FRAC_W - LSB_WT;
    if (pos >= 0) mag = sigW << pos;
    else begin
      mag = sigW >> (-pos);
      if ((sigW & ((BW'(1) << (-pos)) - BW'(1))) != '0) mInx = 1'b1;
    end
    lim = BW'(1) << (ACC_W - 1);
    if (mag >= lim) begin mOvf = 1'b1; return; end
    w = {{(BW-ACC_W){mSum[ACC_W-1]}}, mSum};
    if (f[31]) w = w - $signed(mag);
    else       w = w + $signed(mag);
    slim = $signed(lim);
    if (w >= slim || w < -slim) mOvf = 1'b1;
    mSum = w[ACC_W-1:0];
  endfunction

  function automatic void push(input int due, input string req);
    item_t it;
    it.due = due; it.sum = mSum; it.ovf = mOvf; it.inx = mInx; it.inv = mInv;
    it.req = req;
    sb.push_back(it);
  endfunction

  // Driver tasks: entered at negedge+1, leave one cycle later.
  task automatic sendOne(input logic [31:0] f, input string req);
    inValid = 1'b1; inData = f; clear = 1'b0;
    modelAdd(f);
    push(cyc + 2, req);
    @(negedge clk); #1;
    inValid = 1'b0;
  endtask

  task automatic idleCheck(input string req);
    inValid = 1'b0; clear = 1'b0;
    push(cyc + 2, req);
    @(negedge clk); #1;
  endtask

  task automatic doClear(input logic withSummand, input logic [31:0] f, input string req);
    for (int i = sb.size() - 1; i >= 0; i--)
      if (sb[i].due > cyc) sb.delete(i);
    mSum = '0; mOvf = 1'b0; mInx = 1'b0; mInv = 1'b0;
    clear = 1'b1; inValid = withSummand; inData = f;
    push(cyc + 1, req);
    push(cyc + 2, req);
    @(negedge clk); #1;
    clear = 1'b0; inValid = 1'b0;
  endtask

  // Monitor: compares due items at the falling edge.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due == cyc) begin
      item_t it;
      it = sb.pop_front();
      checkCnt++;
      if (accSum !== it.sum || overflow !== it.ovf || inexact !== it.inx || invalid !== it.inv) begin
        failCnt++;
        $display("FAIL %s: sum=%h ovf=%b inx=%b inv=%b expected sum=%h ovf=%b inx=%b inv=%b",
                 it.req, accSum, overflow, inexact, invalid, it.sum, it.ovf, it.inx, it.inv);
      end
    end
  end

  initial begin
    #400000;
    failCnt++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    // R11: reset state
    checkCnt++;
    if (accSum !== '0 || overflow || inexact || invalid) begin
      failCnt++;
      $display("FAIL R11: sum=%h flags=%b%b%b expected zero", accSum, overflow, inexact, invalid);
    end

    sendOne(fp(0, 127, 0), "R1");            // +1.0
    sendOne(fp(0, 0, 0), "R4");              // +0, stays exact
    sendOne(fp(0, 127, 24'h400000), "R2");   // +1.5 back-to-back
    sendOne(fp(1, 125, 0), "R3");            // -0.25
    idleCheck("R10");
    idleCheck("R10");

    doClear(1'b1, fp(0, 127, 0), "R8");      // summand with clear is dropped
    sendOne(fp(0, 127, 0), "R8");
    doClear(1'b0, 32'h0, "R8");              // previous summand in flight dropped

    // R9: ripple through both halves
    sendOne(fp(0, 89, 0), "R9");             // +1 LSB
    sendOne(fp(1, 90, 0), "R9");             // -2 -> all ones
    sendOne(fp(0, 89, 0), "R9");             // back to zero

    sendOne(fp(0, 100, 12'hFFF), "R5");      // low bits dropped
    sendOne(fp(1, 100, 12'h800), "R5");      // negative, truncated magnitude

    doClear(1'b0, 32'h0, "R8");
    sendOne(fp(0, 0, 5), "R4");              // subnormal: hidden bit 0
    sendOne(fp(0, 255, 0), "R7");            // infinity
    sendOne(fp(0, 151, 0), "R6");            // oversized summand

    doClear(1'b0, 32'h0, "R8");
    sendOne(fp(0, 150, 0), "R6");            // 2^61
    sendOne(fp(0, 150, 0), "R6");            // wraps past 2^62-1
    idleCheck("R10");

    doClear(1'b0, 32'h0, "R8");
    for (int i = 0; i < 12; i++)
      sendOne(fp(logic'(i % 3 == 1), 110 + i * 3, (i * 24'h13579) & 24'h7FFFFF), "R2");
    idleCheck("R2");

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule